// File: doc/BRIEF.md
# Quadword-Fed Contiguous Dispatch Queue

This block sits between an instruction cache and the issue logic of a wide in-order core. The cache hands it groups of four 32-bit instructions that always start on a 128-bit boundary. The issue logic wants something different: the four oldest instructions that have not yet issued, in program order, wherever they fall relative to those boundaries. Each cycle the issue logic reports how many of the presented instructions it took, from none to all four. The queue then shifts the rest forward with no gap.

The queue is built from three stores: a small FIFO of whole quadwords, a single staging quadword, and four issue registers. Each issue register is tied to one address lane (address bits [3:2]), so it only ever chooses between three sources: keep its value, take its lane from the staging quadword, or take its lane from the next quadword. The next quadword is the FIFO head, or the fetch input passed straight through when the FIFO is empty. A rotating pointer marks the lane of the oldest instruction. The four outputs are read starting at that lane and wrap around, so the presented group stays contiguous. When the staging quadword runs out exactly, it is reloaded on the following cycle. Lanes that wrap past it are filled directly from the next quadword in the same cycle that the next quadword moves into staging. A flush input empties everything in one cycle, and the stream restarts at lane 0.

Top module: `quad_issue_queue`

## Requirements
- R1: In the first cycle after reset, no output slot is valid and `fetch_ready` is 1.
- R2: `out_valid` is always a thermometer code that fills from slot 0: if slot j is valid, every slot below j is valid.
- R3: A dequeue count n removes output slots 0..n-1. In the next cycle, slot 0 holds the instruction that was in slot n, and the order of all remaining instructions is preserved. n must not exceed the number of valid slots.
- R4: A dequeue count of 0 leaves every valid output slot and its instruction unchanged.
- R5: `fetch_ready` is 0 exactly when all DEPTH FIFO entries are occupied. With nothing dequeued, the queue accepts 2+DEPTH quadwords (issue registers, staging, FIFO) before `fetch_ready` falls.
- R6: When the queue is empty, a quadword accepted at a clock edge is presented on all four slots one edge later. Lane 0 of `fetch_quad` is bits [31:0], and lane 0 goes out on slot 0.
- R7: With a quadword offered every cycle and all four slots dequeued every cycle, all four slots stay valid every cycle once the stream is running.
- R8: A cycle with `flush` at 1 leaves no valid slot and an empty FIFO on the next cycle, and any quadword offered in that cycle is dropped. The next accepted quadword then starts on slot 0.
- R9: For any mix of dequeue counts 0..4 and any gaps in fetch, the sequence of dequeued instructions equals the sequence of accepted instructions, lane 0 first within each quadword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued instructions |
| fetch_valid | input | 1 | `fetch_quad` holds an aligned quadword |
| fetch_ready | output | 1 | A quadword can be accepted this cycle |
| fetch_quad | input | LANES*IW | Four instructions, lane 0 in the low bits |
| out_valid | output | LANES | Per-slot valid, slot 0 is the oldest |
| out_instr | output | LANES*IW | Slot j in bits [j*IW +: IW] |
| deq_cnt | input | $clog2(LANES+1) | Number of slots issued this cycle |

## Verification
The bench builds the block with its defaults: four lanes of 32 bits and a FIFO depth of two. At this depth `fetch_ready` falls after only four quadwords, so the fill boundary, the stalled-fetch path and the FIFO bypass are all reached within a few cycles. A long stretch of mixed dequeue counts, together with fetch that is held back at random, moves the oldest-lane pointer through all four lanes. This drives the case where slots wrap past the staging quadword into the next quadword, as well as the case where staging runs out exactly and is reloaded one cycle later. A scoreboard then checks that nothing is lost, duplicated or reordered.

// File: rtl/qiq_pkg.sv
package qiq_pkg;
  // Source chosen by one issue register for the coming cycle.
  typedef enum logic [1:0] {
    SRC_KEEP   = 2'd0,
    SRC_ONDECK = 2'd1,
    SRC_NEXT   = 2'd2
  } slot_src_e;
endpackage

// File: rtl/qiq_buffer.sv
module qiq_buffer #(
  parameter int W     = 128,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head_data = mem[rd_ptr];
  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));

  // R5: no write into a full FIFO, no read from an empty one
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && !flush) |-> !push);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/qiq_stage.sv
module qiq_stage
  import qiq_pkg::*;
#(
  parameter int IW    = 32,
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [CW-1:0]       deq_cnt,
  input  logic                nxt_avail,
  input  logic [LANES*IW-1:0] nxt_data,
  output logic                nxt_take,
  output logic [LANES-1:0]    slot_v,
  output logic [LANES*IW-1:0] slot_d,
  output logic [LW-1:0]       head
);
  logic [IW-1:0]    slot_q [LANES];
  logic [IW-1:0]    odk_q  [LANES];
  logic [LANES-1:0] odk_v;
  logic [LANES-1:0] keep, from_odk, from_nxt;
  slot_src_e        src [LANES];
  logic             advance;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LW-1:0] rel;
    assign rel         = LW'(k) - head;
    assign keep[k]     = slot_v[k] && (CW'(rel) >= deq_cnt);
    assign from_odk[k] = !keep[k] && odk_v[k];
    assign from_nxt[k] = !keep[k] && !odk_v[k] && nxt_avail;
    assign src[k]      = keep[k]     ? SRC_KEEP   :
                         from_odk[k] ? SRC_ONDECK :
                         from_nxt[k] ? SRC_NEXT   : SRC_KEEP;
    assign slot_d[k*IW +: IW] = slot_q[k];
  end

  // Load staging when it was already empty (deferred reload) or when
  // wrapped lanes draw on the next quadword in this cycle.
  assign advance  = nxt_avail && ((odk_v == '0) || (from_nxt != '0));
  assign nxt_take = advance && !flush;

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      case (src[k])
        SRC_ONDECK: slot_q[k] <= odk_q[k];
        SRC_NEXT:   slot_q[k] <= nxt_data[k*IW +: IW];
        default:    slot_q[k] <= slot_q[k];
      endcase
      if (advance) odk_q[k] <= nxt_data[k*IW +: IW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      slot_v <= '0;
      odk_v  <= '0;
      head   <= '0;
    end else begin
      slot_v <= keep | from_odk | from_nxt;
      head   <= head + deq_cnt[LW-1:0];
      odk_v  <= advance ? ~from_nxt : (odk_v & ~from_odk);
    end
  end

  // R8: one flush cycle empties issue registers and staging
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (slot_v == '0) && (odk_v == '0));
  // R9: staging never holds lanes while issue registers have a hole
  a_r9_staging_behind: assert property (@(posedge clk) disable iff (rst)
    (odk_v != '0) |-> (slot_v == '1));
endmodule

// File: rtl/qiq_rotate.sv
module qiq_rotate #(
  parameter int IW    = 32,
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LW-1:0]       head,
  input  logic [LANES-1:0]    slot_v,
  input  logic [LANES*IW-1:0] slot_d,
  output logic [LANES-1:0]    out_v,
  output logic [LANES*IW-1:0] out_d
);
  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [LW-1:0] idx;
    assign idx                = head + LW'(j);
    assign out_v[j]           = slot_v[idx];
    assign out_d[j*IW +: IW]  = slot_d[idx*IW +: IW];
  end
endmodule

// File: rtl/quad_issue_queue.sv
module quad_issue_queue #(
  parameter int IW    = 32,
  parameter int LANES = 4,
  parameter int DEPTH = 2,
  localparam int LW   = $clog2(LANES),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                fetch_valid,
  output logic                fetch_ready,
  input  logic [LANES*IW-1:0] fetch_quad,
  output logic [LANES-1:0]    out_valid,
  output logic [LANES*IW-1:0] out_instr,
  input  logic [CW-1:0]       deq_cnt
);
  localparam int QW = LANES * IW;

  logic          fire, buf_empty, buf_full, nxt_avail, nxt_take;
  logic [QW-1:0] buf_head, nxt_data, slot_d;
  logic [LANES-1:0] slot_v;
  logic [LW-1:0] head;

  assign fetch_ready = !buf_full;
  assign fire        = fetch_valid && fetch_ready && !flush;
  assign nxt_avail   = !buf_empty || fire;
  assign nxt_data    = buf_empty ? fetch_quad : buf_head;

  qiq_buffer #(.W(QW), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (fire && !(buf_empty && nxt_take)),
    .push_data (fetch_quad),
    .pop       (nxt_take && !buf_empty),
    .head_data (buf_head),
    .empty     (buf_empty),
    .full      (buf_full)
  );

  qiq_stage #(.IW(IW), .LANES(LANES)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .deq_cnt   (deq_cnt),
    .nxt_avail (nxt_avail),
    .nxt_data  (nxt_data),
    .nxt_take  (nxt_take),
    .slot_v    (slot_v),
    .slot_d    (slot_d),
    .head      (head)
  );

  qiq_rotate #(.IW(IW), .LANES(LANES)) u_rot (
    .head   (head),
    .slot_v (slot_v),
    .slot_d (slot_d),
    .out_v  (out_valid),
    .out_d  (out_instr)
  );

  // R1: empty and ready right after reset
  a_r1_reset_empty: assert property (@(posedge clk)
    $fell(rst) |-> (out_valid == '0) && fetch_ready);
  // R2: valid slots form a thermometer from slot 0
  a_r2_contiguous: assert property (@(posedge clk) disable iff (rst)
    (out_valid & (out_valid + 1'b1)) == '0);
  // R3: the issue logic never takes more than is presented
  a_r3_deq_legal: assert property (@(posedge clk) disable iff (rst)
    !flush |-> (int'(deq_cnt) <= $countones(out_valid)));
  // R3: the instruction behind the issued ones moves to slot 0
  for (genvar n = 1; n < LANES; n++) begin : g_shift
    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
      (int'(deq_cnt) == n && out_valid[n] && !flush) |=>
        out_valid[0] && (out_instr[IW-1:0] == $past(out_instr[n*IW +: IW])));
  end
  // R4: nothing issued, oldest slot unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (deq_cnt == '0 && out_valid[0] && !flush) |=>
      out_valid[0] && $stable(out_instr[IW-1:0]));
endmodule

// File: tb/quad_issue_queue_bench.sv
`timescale 1ns/1ps
module quad_issue_queue_bench;
  localparam int IW = 32, LANES = 4, DEPTH = 2;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0, fetch_valid = 1'b0;
  logic fetch_ready;
  logic [LANES*IW-1:0] fetch_quad = '0, out_instr;
  logic [LANES-1:0] out_valid;
  logic [2:0] deq_cnt = '0;

  int checks = 0, failures = 0, accepted = 0;
  bit done = 1'b0;
  logic [IW-1:0] exp_q[$];
  logic [IW-1:0] seq = 32'hA500_0000;

  always #4 clk = ~clk;

  quad_issue_queue #(.IW(IW), .LANES(LANES), .DEPTH(DEPTH)) u_quad_issue_queue (
    .clk(clk), .rst(rst), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_quad(fetch_quad), .out_valid(out_valid),
    .out_instr(out_instr), .deq_cnt(deq_cnt));

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] slot(input int j);
    return out_instr[j*IW +: IW];
  endfunction

  // One cycle, called just after a falling edge: monitor then driver.
  task automatic step(input bit want_fetch, input int deq_want, input string req);
    int nv, d;
    nv = $countones(out_valid);
    check((out_valid & (out_valid + 1'b1)) == '0, "R2 thermometer", 128'(out_valid), 128'(out_valid));
    d = (deq_want < nv) ? deq_want : nv;
    for (int j = 0; j < d; j++) begin
      if (exp_q.size() == 0) check(1'b0, req, 128'(slot(j)), 128'h0);
      else check(slot(j) == exp_q[0], req, 128'(slot(j)), 128'(exp_q[0]));
      if (exp_q.size() != 0) void'(exp_q.pop_front());
    end
    deq_cnt = 3'(d);
    fetch_valid = want_fetch;
    for (int l = 0; l < LANES; l++) fetch_quad[l*IW +: IW] = seq + 32'(l);
    if (want_fetch && fetch_ready) begin
      for (int l = 0; l < LANES; l++) exp_q.push_back(seq + 32'(l));
      seq = seq + 32'(LANES);
      accepted++;
    end
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) step(1'b0, 4, req);
    step(1'b0, 0, req);
    check(exp_q.size() == 0 && out_valid == '0, req, 128'(out_valid), 128'h0);
  endtask

  initial begin
    logic [IW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == '0, "R1 out_valid after reset", 128'(out_valid), 128'h0);
    check(fetch_ready == 1'b1, "R1 fetch_ready after reset", 128'(fetch_ready), 128'h1);

    // R6 bypass: one quadword into an empty queue shows one edge later
    step(1'b1, 0, "R6");
    check(out_valid == 4'hF, "R6 all slots valid", 128'(out_valid), 128'hF);
    check(slot(0) == exp_q[0] && slot(3) == exp_q[3], "R6 lane order", 128'(out_instr), 128'(exp_q[0]));

    // R5 fill with nothing dequeued; R4 hold on slot 0
    held = slot(0);
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 0, "R4");
      check(out_valid[0] && slot(0) == held, "R4 hold", 128'(slot(0)), 128'(held));
    end
    check(accepted == 2 + DEPTH, "R5 quadwords accepted", 128'(accepted), 128'(2 + DEPTH));
    check(fetch_ready == 1'b0, "R5 ready low when full", 128'(fetch_ready), 128'h0);
    fetch_valid = 1'b0;
    drain("R3 drain");

    // R3 single and partial dequeues across quadword boundaries
    step(1'b1, 0, "R3"); step(1'b1, 0, "R3");
    for (int i = 0; i < 12; i++) step(1'b0, (i % 3) + 1, "R3 partial dequeue");
    drain("R3 drain");

    // R7 sustained full-width streaming
    for (int i = 0; i < 60; i++) begin
      if (i >= 2) check(out_valid == 4'hF, "R7 full every cycle", 128'(out_valid), 128'hF);
      step(1'b1, 4, "R7");
    end
    drain("R7 drain");

    // R8 flush in the middle of a stream, with a quadword offered
    step(1'b1, 1, "R8"); step(1'b1, 2, "R8"); step(1'b1, 0, "R8");
    flush = 1'b1; deq_cnt = '0; fetch_valid = 1'b1;
    @(negedge clk);
    flush = 1'b0; fetch_valid = 1'b0; exp_q.delete();
    check(out_valid == '0, "R8 empty after flush", 128'(out_valid), 128'h0);
    check(fetch_ready == 1'b1, "R8 fifo empty after flush", 128'(fetch_ready), 128'h1);
    step(1'b1, 0, "R8");
    check(out_valid == 4'hF && slot(0) == exp_q[0], "R8 restart at slot 0", 128'(slot(0)), 128'(exp_q[0]));
    drain("R8 drain");

    // R9 mixed dequeue counts and fetch gaps
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, int'($urandom % 5), "R9 order");
    fetch_valid = 1'b0;
    drain("R9 drain");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule